// File: doc/BRIEF.md
# Real-Time Clock Update Scheduler with Divider Restart

This block sets the timing of the once-per-second update of a CMOS-style real-time clock. A sub-second phase counter steps on every tick of a fixed timebase clock. When it wraps it produces a one-cycle update strobe, which the calendar counters elsewhere use to advance the time. An update-in-progress flag is raised for a short, configurable window before each strobe. Software reads this flag through bit 7 of control register A.

Software controls the divider through two byte-wide registers. The divider-select field of register A can hold the divider in reset. A later write that picks a valid time base releases it, and the phase is then loaded to mid-second, so the first update comes exactly half a second after the release. If the set bit of register B is active at the moment of release, the restart is deferred and recorded as pending. The restart then happens when software clears the set bit. Every other way of leaving set mode keeps the sub-second phase where it was.

Top module: `rtc_update_sched`

## Requirements
- R1: A synchronous active-low reset gives phase 0, no strobe, no update-in-progress, set bit 0, nothing pending, and a register A readback of 0x20 (divider field 2, running).
- R2: While the divider runs, the phase counts 0 to TICKS_PER_SEC-1 and wraps to 0. With the set bit at 0, the update strobe is high for exactly the one cycle in which the phase equals TICKS_PER_SEC-1, so there is one strobe every TICKS_PER_SEC cycles.
- R3: Update-in-progress is high for the UIP_TICKS cycles just before each strobe cycle and low in the strobe cycle itself.
- R4: While bits 6 and 5 of register A are both 1, the divider is in reset: the phase holds, and neither a strobe nor update-in-progress appears.
- R5: Writing register A (select 0) while in divider reset, with a new value in bits 6:4 of 2 or less and the set bit at 0, loads the phase to TICKS_PER_SEC/2 and clears update-in-progress. The next wrap follows TICKS_PER_SEC/2 cycles after the write.
- R6: Writing register A in divider reset with a value of 3, 4 or 5 in bits 6:4 loads nothing. The divider leaves reset and continues from its held phase.
- R7: Bit 7 of register A is read-only. The readback shows update-in-progress there, and the written bit 7 is dropped. Bits 6:0 read back as last written.
- R8: A release write made while the set bit is 1 does not load the phase. It records a pending restart, and the phase stays frozen while the restart is pending.
- R9: Writing register B (select 1) with bit 7 at 0 while the set bit is 1 and a restart is pending loads the phase to TICKS_PER_SEC/2, clears update-in-progress and clears the pending restart.
- R10: Setting the set bit, or clearing it with no restart pending, does not disturb the phase, which steps on by one in that cycle.
- R11: While the set bit is 1, no strobe and no update-in-progress appear, though a running phase keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, one tick per phase step |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 for register A, 1 for register B |
| wr_data | input | 8 | Write data |
| upd_stb | output | 1 | One-cycle update strobe at the phase wrap |
| uip | output | 1 | Update-in-progress flag |
| phase | output | $clog2(TICKS_PER_SEC) | Current sub-second divider phase |
| ctl_a_rd | output | 8 | Register A readback, update-in-progress in bit 7 |

## Verification
A register write changes the state at the clock edge on which it is sampled. The phase, strobe, flag and readback are decoded from registers with no path from the inputs, so each write's effect is due one cycle after it is presented. The bench drives inputs on falling edges and compares every output against its behavioural model at every falling edge, which is the first point where that cycle's result is settled. The directed checks count falling edges from a write: the half-second restart must show phase TICKS_PER_SEC/2 at the first one and the strobe TICKS_PER_SEC/2-1 edges later. The update-in-progress window must last exactly UIP_TICKS edges and end on the strobe edge.

// File: rtl/rtc_sched_pkg.sv
// Shared constants for the update scheduler: the register select encoding,
// the field positions that software relies on, and the decode of the
// divider-reset condition. Assumes byte-wide control registers.
package rtc_sched_pkg;

    typedef enum logic {
        SEL_CTL_A = 1'b0,
        SEL_CTL_B = 1'b1
    } ctl_sel_e;

    localparam int DIV_HI  = 6;
    localparam int DIV_LO  = 4;
    localparam int SET_POS = 7;

    localparam logic [2:0] DIV_RUN_MAX = 3'd2;
    localparam logic [6:0] CTL_A_INIT  = 7'h20;

    // True when the divider field holds the divider in reset.
    function automatic logic div_field_held(input logic [2:0] dv);
        return dv[2] & dv[1];
    endfunction

endpackage

// File: rtl/rtc_ctl_regs.sv
// Control register file for the scheduler. Holds the writable bits of
// register A, the set bit of register B and the pending-restart flag.
// Decodes the two events that restart the divider at mid-second.
// Assumes one register write at most per cycle.
module rtc_ctl_regs
    import rtc_sched_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic [6:0] ctl_a_q,
    output logic       set_q,
    output logic       pend_q,
    output logic       restart,
    output logic       held
);

    logic wr_a;
    logic wr_b;
    logic release_req;
    logic set_fall;

    // Event decode for writes, releases and set-bit clears.
    always_comb begin
        wr_a        = wr_en && (ctl_sel_e'(wr_sel) == SEL_CTL_A);
        wr_b        = wr_en && (ctl_sel_e'(wr_sel) == SEL_CTL_B);
        release_req = wr_a && div_field_held(ctl_a_q[DIV_HI:DIV_LO])
                      && (wr_data[DIV_HI:DIV_LO] <= DIV_RUN_MAX);
        set_fall    = wr_b && set_q && !wr_data[SET_POS];
        restart     = (release_req && !set_q) || (set_fall && pend_q);
        held        = div_field_held(ctl_a_q[DIV_HI:DIV_LO]) || pend_q;
    end

    // Register A writable bits; bit 7 is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctl_a_q <= CTL_A_INIT;
        else if (wr_a) ctl_a_q <= wr_data[6:0];
    end

    // Set bit of register B.
    always_ff @(posedge clk) begin
        if (!rst_n)    set_q <= 1'b0;
        else if (wr_b) set_q <= wr_data[SET_POS];
    end

    // Pending restart: recorded on a release under set, consumed on set clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pend_q <= 1'b0;
        else if (release_req && set_q)    pend_q <= 1'b1;
        else if (set_fall && pend_q)      pend_q <= 1'b0;
    end

endmodule

// File: rtl/rtc_phase_div.sv
// Sub-second phase counter. Steps once per clock while running, wraps at
// TICKS_PER_SEC-1 and can be loaded to mid-second. Assumes TICKS_PER_SEC
// is at least 4 so that the mid-second value lies inside the range.
module rtc_phase_div #(
    parameter int TICKS_PER_SEC = 20,
    localparam int PW = $clog2(TICKS_PER_SEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load_half,
    output logic [PW-1:0] phase,
    output logic          at_top
);

    localparam logic [PW-1:0] TOP_P  = PW'(TICKS_PER_SEC - 1);
    localparam logic [PW-1:0] HALF_P = PW'(TICKS_PER_SEC / 2);

    // Flag the last phase of the second.
    always_comb at_top = (phase == TOP_P);

    // Phase register: mid-second load wins over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase <= '0;
        else if (load_half) phase <= HALF_P;
        else if (run)       phase <= at_top ? '0 : phase + 1'b1;
    end

endmodule

// File: rtl/rtc_upd_timing.sv
// Decodes the update strobe and the update-in-progress window from the
// phase. Both are suppressed while the divider is held or set mode is on.
// Assumes UIP_TICKS is below TICKS_PER_SEC/2 - 1 so the window never
// overlaps a freshly loaded mid-second phase.
module rtc_upd_timing #(
    parameter int TICKS_PER_SEC = 20,
    parameter int UIP_TICKS     = 3,
    localparam int PW = $clog2(TICKS_PER_SEC)
) (
    input  logic          run,
    input  logic          set_mode,
    input  logic          at_top,
    input  logic [PW-1:0] phase,
    output logic          upd_stb,
    output logic          uip
);

    logic active;

    // Updates only happen on a running divider outside set mode.
    always_comb begin
        active  = run && !set_mode;
        upd_stb = active && at_top;
    end

    generate
        if (UIP_TICKS == 0) begin : g_no_uip
            // No warning window configured.
            always_comb uip = 1'b0;
        end else begin : g_uip
            localparam logic [PW-1:0] FIRST_P = PW'(TICKS_PER_SEC - 1 - UIP_TICKS);
            // Window covers the UIP_TICKS phases ahead of the top phase.
            always_comb uip = active && (phase >= FIRST_P) && !at_top;
        end
    endgenerate

endmodule

// File: rtl/rtc_update_sched.sv
// Top of the update scheduler. Connects the control registers, the phase
// counter and the update decode, and returns register A with the
// update-in-progress flag in its read-only top bit. Assumes a timebase
// clock that ticks TICKS_PER_SEC times per second.
module rtc_update_sched #(
    parameter int TICKS_PER_SEC = 20,
    parameter int UIP_TICKS     = 3,
    localparam int PW = $clog2(TICKS_PER_SEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [7:0]    wr_data,
    output logic          upd_stb,
    output logic          uip,
    output logic [PW-1:0] phase,
    output logic [7:0]    ctl_a_rd
);

    logic [6:0] ctl_a_q;
    logic       set_q;
    logic       pend_q;
    logic       restart;
    logic       held;
    logic       run;
    logic       at_top;

    // The divider runs unless its field holds it or a restart waits.
    always_comb run = !held;

    rtc_ctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctl_a_q (ctl_a_q),
        .set_q   (set_q),
        .pend_q  (pend_q),
        .restart (restart),
        .held    (held)
    );

    rtc_phase_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .load_half (restart),
        .phase     (phase),
        .at_top    (at_top)
    );

    rtc_upd_timing #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .UIP_TICKS     (UIP_TICKS)
    ) u_tim (
        .run      (run),
        .set_mode (set_q),
        .at_top   (at_top),
        .phase    (phase),
        .upd_stb  (upd_stb),
        .uip      (uip)
    );

    // Register A readback with the live flag in the read-only bit.
    always_comb ctl_a_rd = {uip, ctl_a_q};

endmodule

// File: rtl/rtc_update_sched_chk.sv
// Property checker for the update scheduler, attached by bind. Observes
// writes, the set and pending state, and the scheduler outputs.
module rtc_update_sched_chk #(
    parameter int TICKS_PER_SEC = 20,
    localparam int PW = $clog2(TICKS_PER_SEC)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_sel,
    input logic [2:0]    div_new,
    input logic          set_new,
    input logic          dv_held,
    input logic          set_q,
    input logic          pend_q,
    input logic          upd_stb,
    input logic          uip,
    input logic [PW-1:0] phase
);

    localparam logic [PW-1:0] TOP_P  = PW'(TICKS_PER_SEC - 1);
    localparam logic [PW-1:0] HALF_P = PW'(TICKS_PER_SEC / 2);

    p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= TOP_P);

    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_held && !wr_en) |=> ($stable(phase) && !upd_stb && !uip));

    p_release_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && dv_held && div_new <= 3'd2 && !set_q)
        |=> (phase == HALF_P && !uip));

    p_release_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && dv_held && div_new <= 3'd2 && set_q)
        |=> (pend_q && $stable(phase)));

    p_set_clear_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && set_q && !set_new && pend_q)
        |=> (phase == HALF_P && !pend_q && !uip));

    p_keep_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !pend_q && !dv_held)
        |=> (phase == (($past(phase) == TOP_P) ? '0 : $past(phase) + 1'b1)));

    p_quiet_in_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_q |-> (!upd_stb && !uip));

endmodule

bind rtc_update_sched rtc_update_sched_chk #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .div_new (wr_data[6:4]),
    .set_new (wr_data[7]),
    .dv_held (&ctl_a_q[6:5]),
    .set_q   (set_q),
    .pend_q  (pend_q),
    .upd_stb (upd_stb),
    .uip     (uip),
    .phase   (phase)
);

// File: tb/rtc_update_sched_tb.sv
module rtc_update_sched_tb;

    localparam int T    = 20;
    localparam int U    = 3;
    localparam int HALF = T / 2;
    localparam int PW   = $clog2(T);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          upd_stb;
    logic          uip;
    logic [PW-1:0] phase;
    logic [7:0]    ctl_a_rd;

    int total = 0;
    int bad   = 0;

    // behavioural model state
    int m_ph   = 0;
    int m_a    = 32'h20;
    int m_set  = 0;
    int m_pend = 0;

    always #10 clk = ~clk;

    rtc_update_sched #(.TICKS_PER_SEC(T), .UIP_TICKS(U)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .upd_stb  (upd_stb),
        .uip      (uip),
        .phase    (phase),
        .ctl_a_rd (ctl_a_rd)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_all();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic int m_dv_held();
        return (((m_a >> 5) & 3) == 3) ? 1 : 0;
    endfunction

    function automatic int m_active();
        return (m_dv_held() == 0 && m_pend == 0 && m_set == 0) ? 1 : 0;
    endfunction

    function automatic int m_stb();
        return (m_active() == 1 && m_ph == T - 1) ? 1 : 0;
    endfunction

    function automatic int m_uip();
        return (m_active() == 1 && m_ph >= T - 1 - U && m_ph <= T - 2) ? 1 : 0;
    endfunction

    // model update on each rising edge
    always @(posedge clk) begin
        int nph;
        if (!rst_n) begin
            m_ph = 0; m_a = 32'h20; m_set = 0; m_pend = 0;
        end else begin
            if (m_dv_held() == 1 || m_pend == 1) nph = m_ph;
            else nph = (m_ph == T - 1) ? 0 : m_ph + 1;
            if (wr_en && !wr_sel) begin
                if (m_dv_held() == 1 && int'(wr_data[6:4]) <= 2) begin
                    if (m_set == 0) nph = HALF;
                    else m_pend = 1;
                end
                m_a = int'(wr_data) & 32'h7f;
            end
            if (wr_en && wr_sel) begin
                if (m_set == 1 && !wr_data[7] && m_pend == 1) begin
                    nph = HALF;
                    m_pend = 0;
                end
                m_set = wr_data[7] ? 1 : 0;
            end
            m_ph = nph;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 phase", int'(phase), m_ph);
            check("R2 upd_stb", int'(upd_stb), m_stb());
            check("R3 uip", int'(uip), m_uip());
            check("R7 ctl_a_rd", int'(ctl_a_rd), (m_uip() << 7) | m_a);
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1, 0);
        finish_all();
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_cycles(input int n, output int stbs, output int uips);
        stbs = 0; uips = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            stbs += int'(upd_stb);
            uips += int'(uip);
        end
    endtask

    task automatic cycles_to_stb(output int n);
        n = 0;
        while (!upd_stb && n < 4 * T) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int s, u, n, p;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 phase", int'(phase), 0);
        check("R1 upd_stb", int'(upd_stb), 0);
        check("R1 uip", int'(uip), 0);
        check("R1 ctl_a_rd", int'(ctl_a_rd), 8'h20);
        rst_n = 1'b1;

        // R2 one strobe per second
        count_cycles(2 * T, s, u);
        check("R2 strobes in two seconds", s, 2);

        // R3 uip window length and end
        do @(negedge clk); while (!uip);
        n = 0;
        while (uip) begin
            n++;
            @(negedge clk);
        end
        check("R3 uip cycles", n, U);
        check("R3 strobe ends window", int'(upd_stb), 1);

        // R7 bit 7 is read-only
        @(negedge clk);
        wr(1'b0, 8'hA0);
        check("R7 low bits", int'(ctl_a_rd[6:0]), 8'h20);
        check("R7 top bit is uip", int'(ctl_a_rd[7]), int'(uip));

        // R4 divider reset freezes
        wr(1'b0, 8'h60);
        p = int'(phase);
        count_cycles(2 * T, s, u);
        check("R4 phase held", int'(phase), p);
        check("R4 no strobe", s, 0);
        check("R4 no uip", u, 0);

        // R6 non-release value resumes without load
        wr(1'b0, 8'h30);
        check("R6 phase not loaded", int'(phase), p);
        @(negedge clk);
        check("R6 phase resumes", int'(phase), (p + 1) % T);
        wr(1'b0, 8'h70);

        // R5 half-second restart
        p = int'(phase);
        wr(1'b0, 8'h20);
        check("R5 phase at half", int'(phase), HALF);
        check("R5 uip cleared", int'(uip), 0);
        cycles_to_stb(n);
        check("R5 edges to first strobe", n, T - 1 - HALF);

        // R10 and R11 set mode
        p = int'(phase);
        wr(1'b1, 8'h80);
        check("R10 set keeps phase", int'(phase), (p + 1) % T);
        count_cycles(2 * T, s, u);
        check("R11 no strobe in set", s, 0);
        check("R11 no uip in set", u, 0);
        p = int'(phase);
        wr(1'b1, 8'h00);
        check("R10 clear keeps phase", int'(phase), (p + 1) % T);

        // R8 release under set is deferred
        wr(1'b0, 8'h60);
        wr(1'b1, 8'h80);
        p = int'(phase);
        wr(1'b0, 8'h20);
        check("R8 no load under set", int'(phase), p);
        count_cycles(T, s, u);
        check("R8 phase frozen while pending", int'(phase), p);
        check("R8 no strobe while pending", s, 0);

        // R9 set clear performs pending restart
        wr(1'b1, 8'h00);
        check("R9 phase at half", int'(phase), HALF);
        check("R9 uip cleared", int'(uip), 0);
        cycles_to_stb(n);
        check("R9 edges to first strobe", n, T - 1 - HALF);

        // R9 pending is consumed: a second clear does not reload
        wr(1'b1, 8'h80);
        p = int'(phase);
        wr(1'b1, 8'h00);
        check("R9 no second restart", int'(phase), (p + 1) % T);

        repeat (4) @(negedge clk);
        finish_all();
    end

endmodule